// File: doc/BRIEF.md
# SIMD Element and Bit Reversal Unit

This block is a one-stage permutation datapath for a vector execution pipe. It takes a 128-bit source operand together with a command and, one clock later, presents the permuted result with a valid strobe. Three of its operations reverse the order of elements within fixed-size containers of 16, 32 or 64 bits. The containers themselves stay where they are. The element width is bytes, halfwords or words. The fourth operation mirrors the bit order inside every byte.

The command can come in two ways. It can be given as separate fields: width flag, element size and operation. It can also be given as a 32-bit instruction word, which the unit decodes itself. Register-number fields in the word are not used, since register-file access belongs to the surrounding pipe. A width flag of 0 selects the 64-bit form, in which only the low half is permuted and the high half of the result is cleared. Combinations where the element is not smaller than its container are reported as illegal, and their result is zero.

Top module: `simd_rev_unit`

## Requirements
- R1: After reset, out_valid, out_illegal and out_data are all zero. out_valid is 1 in exactly the cycles that follow a cycle with in_valid high.
- R2: Operation code 2'b00 reverses element order inside each 64-bit container. Element width is 8 << size, with size 0 = byte, 1 = halfword, 2 = word.
- R3: Operation code 2'b01 reverses element order inside each 32-bit container.
- R4: Operation code 2'b10 reverses element order inside each 16-bit container.
- R5: Operation code 2'b11 moves bit i of every byte to bit 7-i of the same byte. In field mode the size field has no effect on this operation.
- R6: With the width flag at 0, only bits 63:0 are permuted and out_data[127:64] is zero, whatever src[127:64] holds. With the flag at 1 all 128 bits are permuted.
- R7: For operation codes 0 to 2, a command with op + size >= 3 is illegal. An illegal command gives out_illegal = 1 and out_data = 0 in the same cycle as out_valid. Examples are 16-bit containers with halfwords, 32-bit containers with words, and size 3 with any reversal.
- R8: With use_word = 1, the command is decoded from insn, and q_in, size_in and op_in have no effect. The word fields are: width flag in bit 30, size in bits 23:22, U in bit 29 and o0 in bit 12. The recognised byte-form words are 0x0E200820 (64-bit containers), 0x2E200820 (32-bit), 0x0E201820 (16-bit) and 0x2E605820 (bit reverse, size 01 only). Any other word is illegal.
- R9: While in_valid is low, out_data keeps its last value and out_illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command and operand strobe |
| use_word | input | 1 | 1: decode insn; 0: use the separate fields |
| insn | input | 32 | Instruction word (word mode) |
| q_in | input | 1 | Width flag, 1 = 128-bit form (field mode) |
| size_in | input | 2 | Element size code (field mode) |
| op_in | input | 2 | Operation code (field mode) |
| src | input | 128 | Source operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_illegal | output | 1 | Command was an unallocated combination |
| out_data | output | 128 | Permuted result |

## Verification
The bench builds the unit with its default 128-bit vector width, the only width at which both the 64-bit and 128-bit forms exist. At that width, every operation and size pair is reachable in both forms, including the illegal pairs at the container boundary. Each pair is driven once through the separate fields and once through the instruction word, with conflicting field inputs on the side. This shows that the decoder and the field path reach the same permutation.

// File: rtl/simd_rev_pkg.sv
`timescale 1ns/1ps
package simd_rev_pkg;

  // Operation select, encoded as {o0, U}
  typedef enum logic [1:0] {
    OP_C64    = 2'b00,
    OP_C32    = 2'b01,
    OP_C16    = 2'b10,
    OP_BITREV = 2'b11
  } rev_op_e;

  typedef struct packed {
    logic      q;     // 1: 128-bit form
    logic [1:0] size; // element size code
    rev_op_e   op;
    logic      bad;   // unallocated combination
  } rev_cmd_t;

  // Element not smaller than container
  function automatic logic is_unalloc(rev_op_e op, logic [1:0] size);
    return (op != OP_BITREV) && (({1'b0, op} + {1'b0, size}) >= 3'd3);
  endfunction

  // Source byte feeding output byte b: XOR with (container bytes - element bytes)
  function automatic int unsigned rev_src_index(int unsigned b, rev_op_e op,
                                                logic [1:0] size);
    int unsigned cont_bytes;
    int unsigned elem_bytes;
    cont_bytes = 32'd8 >> op;
    elem_bytes = 32'd1 << size;
    return b ^ (cont_bytes - elem_bytes);
  endfunction

  function automatic logic [7:0] mirror_byte(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return r;
  endfunction

endpackage

// File: rtl/simd_rev_decode.sv
`timescale 1ns/1ps
module simd_rev_decode
  import simd_rev_pkg::*;
(
  input  logic        use_word,
  input  logic [31:0] insn,
  input  logic        q_in,
  input  logic [1:0]  size_in,
  input  logic [1:0]  op_in,
  output rev_cmd_t    cmd
);

  logic       frame_ok;
  logic       w_q;
  logic [1:0] w_size;
  rev_op_e    w_op;
  logic       w_bad;
  logic [4:0] w_opc;
  logic       w_u;

  // Register-number fields belong to the register file, not this unit
  wire unused_reg_fields = ^insn[9:0];

  assign w_opc = insn[16:12];
  assign w_u   = insn[29];

  always_comb begin
    w_q      = insn[30];
    w_size   = insn[23:22];
    w_op     = OP_C64;
    w_bad    = 1'b0;
    frame_ok = !insn[31] && (insn[28:24] == 5'b01110) && insn[21] &&
               (insn[20:17] == 4'b0000) && (insn[11:10] == 2'b10);
    if (!frame_ok) begin
      w_bad = 1'b1;
    end else if (w_opc == 5'b00000) begin
      w_op = w_u ? OP_C32 : OP_C64;
    end else if ((w_opc == 5'b00001) && !w_u) begin
      w_op = OP_C16;
    end else if ((w_opc == 5'b00101) && w_u && (insn[23:22] == 2'b01)) begin
      w_op = OP_BITREV;
    end else begin
      w_bad = 1'b1;
    end
  end

  always_comb begin
    if (use_word) begin
      cmd.q    = w_q;
      cmd.size = w_size;
      cmd.op   = w_op;
    end else begin
      cmd.q    = q_in;
      cmd.size = size_in;
      cmd.op   = rev_op_e'(op_in);
    end
    cmd.bad = (use_word && w_bad) || is_unalloc(cmd.op, cmd.size);
  end

endmodule

// File: rtl/simd_rev_perm.sv
`timescale 1ns/1ps
module simd_rev_perm
  import simd_rev_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8
) (
  input  rev_cmd_t          cmd,
  input  logic [VEC_W-1:0]  src,
  output logic [VEC_W-1:0]  res
);

  localparam int NBYTES     = VEC_W / BYTE_W;
  localparam int HALF_BYTES = NBYTES / 2;
  localparam int IDX_W      = $clog2(NBYTES);

  logic [NBYTES-1:0][BYTE_W-1:0] src_b;
  assign src_b = src;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam bit IN_UPPER = (b >= HALF_BYTES);
    logic [IDX_W-1:0]  pick;
    logic [BYTE_W-1:0] moved;
    logic [BYTE_W-1:0] flipped;
    logic [BYTE_W-1:0] byte_out;

    always_comb begin
      pick    = IDX_W'(rev_src_index(b, cmd.op, cmd.size));
      moved   = src_b[pick];
      flipped = mirror_byte(src_b[b]);
      if (cmd.bad || (IN_UPPER && !cmd.q)) begin
        byte_out = '0;
      end else if (cmd.op == OP_BITREV) begin
        byte_out = flipped;
      end else begin
        byte_out = moved;
      end
    end

    assign res[b*BYTE_W +: BYTE_W] = byte_out;
  end

endmodule

// File: rtl/simd_rev_unit.sv
`timescale 1ns/1ps
module simd_rev_unit
  import simd_rev_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             use_word,
  input  logic [31:0]      insn,
  input  logic             q_in,
  input  logic [1:0]       size_in,
  input  logic [1:0]       op_in,
  input  logic [VEC_W-1:0] src,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [VEC_W-1:0] out_data
);

  localparam int HALF_W = VEC_W / 2;
  localparam int ONES_W = $clog2(VEC_W + 1);

  rev_cmd_t         dec_cmd;
  logic [VEC_W-1:0] perm_res;
  logic             evt_accept;
  logic [ONES_W-1:0] src_ones;

  simd_rev_decode u_decode (
    .use_word (use_word),
    .insn     (insn),
    .q_in     (q_in),
    .size_in  (size_in),
    .op_in    (op_in),
    .cmd      (dec_cmd)
  );

  simd_rev_perm #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_perm (
    .cmd (dec_cmd),
    .src (src),
    .res (perm_res)
  );

  assign evt_accept = in_valid;
  assign src_ones   = ONES_W'($countones(dec_cmd.q ? src
                                         : {{HALF_W{1'b0}}, src[HALF_W-1:0]}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= evt_accept;
      out_illegal <= evt_accept && dec_cmd.bad;
      if (evt_accept) out_data <= perm_res;
    end
  end

  // R1: one-cycle latency on the valid strobe
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |=> !out_valid);

  // R2 R3 R4 R5: every legal permutation keeps the number of set bits
  p_ones_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !dec_cmd.bad) |=>
      (ONES_W'($countones(out_data)) == $past(src_ones)));

  // R6: narrow form clears the upper half
  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !dec_cmd.q) |=> (out_data[VEC_W-1:HALF_W] == '0));

  // R7: illegal flag only with valid, and then the result is zero
  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && (out_data == '0)));

  // R9: result held while idle
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |=> ($stable(out_data) && !out_illegal));

endmodule

// File: tb/simd_rev_unit_bench.sv
`timescale 1ns/1ps
module simd_rev_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         use_word = 1'b0;
  logic [31:0]  insn = '0;
  logic         q_in = 1'b0;
  logic [1:0]   size_in = '0;
  logic [1:0]   op_in = '0;
  logic [127:0] src = '0;
  wire          out_valid;
  wire          out_illegal;
  wire  [127:0] out_data;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  simd_rev_unit u_simd_rev_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_word(use_word),
    .insn(insn), .q_in(q_in), .size_in(size_in), .op_in(op_in), .src(src),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_data(out_data)
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: container/element loops
  function automatic logic [127:0] ref_perm(logic q, logic [1:0] sz, logic [1:0] op,
                                            logic [127:0] s);
    logic [127:0] r;
    int w, es, cs, n;
    r = '0;
    w = q ? 128 : 64;
    if (op == 2'd3) begin
      for (int j = 0; j < w / 8; j++)
        for (int i = 0; i < 8; i++) r[j*8 + 7 - i] = s[j*8 + i];
    end else begin
      es = 8 << sz;
      cs = 64 >> op;
      if (es >= cs) return '0;
      n = cs / es;
      for (int c = 0; c < w / cs; c++)
        for (int e = 0; e < n; e++)
          for (int k = 0; k < es; k++)
            r[c*cs + (n-1-e)*es + k] = s[c*cs + e*es + k];
    end
    return r;
  endfunction

  function automatic logic ref_bad(logic [1:0] sz, logic [1:0] op);
    return (op != 2'd3) && ((int'(op) + int'(sz)) >= 3);
  endfunction

  function automatic logic [31:0] mk_insn(logic q, logic [1:0] sz, logic [1:0] op);
    logic [31:0] w;
    case (op)
      2'd0:    w = 32'h0E200820;
      2'd1:    w = 32'h2E200820;
      2'd2:    w = 32'h0E201820;
      default: w = 32'h2E605820;
    endcase
    if (op != 2'd3) w[23:22] = sz;
    w[30] = q;
    return w;
  endfunction

  function automatic logic [127:0] pattern(int p);
    logic [127:0] v;
    case (p)
      0: for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(i);
      1: v = '1;
      2: v = {16{8'hAA}};
      3: v = {16{8'h55}};
      default: v = 128'h0123456789ABCDEF_FEDCBA9876543210;
    endcase
    return v;
  endfunction

  // Drive one command, check the result, then check idle hold
  task automatic run(string tag, logic uw, logic [31:0] word, logic q, logic [1:0] sz,
                     logic [1:0] op, logic [127:0] s, logic exp_bad,
                     logic [127:0] exp_data);
    @(negedge clk);
    use_word = uw; insn = word; q_in = q; size_in = sz; op_in = op; src = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, {127'd0, out_valid}, 128'd1);
    check({tag, " R7 illegal"}, {127'd0, out_illegal}, {127'd0, exp_bad});
    check({tag, " data"}, out_data, exp_data);
    src = ~s; q_in = ~q; op_in = ~op;
    @(negedge clk);
    check({tag, " R9 hold"}, out_data, exp_data);
    check({tag, " R9 idle"}, {126'd0, out_valid, out_illegal}, 128'd0);
  endtask

  typedef struct packed {
    logic       uw;
    logic       q;
    logic [1:0] sz;
    logic [1:0] op;
    logic [2:0] pat;
    logic       bad;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 1'b1, 2'd0, 2'd0, 3'd0, 1'b0},  // R2 bytes
    '{1'b0, 1'b1, 2'd1, 2'd0, 3'd4, 1'b0},  // R2 halves
    '{1'b0, 1'b0, 2'd2, 2'd0, 3'd4, 1'b0},  // R2 words, R6
    '{1'b0, 1'b1, 2'd0, 2'd1, 3'd0, 1'b0},  // R3 bytes
    '{1'b0, 1'b1, 2'd1, 2'd1, 3'd4, 1'b0},  // R3 halves
    '{1'b0, 1'b1, 2'd0, 2'd2, 3'd0, 1'b0},  // R4 bytes
    '{1'b0, 1'b1, 2'd3, 2'd3, 3'd2, 1'b0},  // R5 size ignored
    '{1'b0, 1'b0, 2'd0, 2'd3, 3'd4, 1'b0},  // R5 narrow, R6
    '{1'b0, 1'b1, 2'd1, 2'd2, 3'd1, 1'b1},  // R7 16-bit / halves
    '{1'b0, 1'b1, 2'd2, 2'd1, 3'd1, 1'b1},  // R7 32-bit / words
    '{1'b0, 1'b1, 2'd3, 2'd0, 3'd1, 1'b1},  // R7 size 3
    '{1'b1, 1'b1, 2'd1, 2'd0, 3'd4, 1'b0},  // R8 word 64-bit halves
    '{1'b1, 1'b0, 2'd0, 2'd3, 3'd4, 1'b0},  // R8 word bit reverse
    '{1'b1, 1'b1, 2'd0, 2'd2, 3'd3, 1'b0}   // R8 word 16-bit
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {out_data[125:0], out_valid, out_illegal}, 128'd0);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      logic [127:0] s;
      s = pattern(int'(TBL[r].pat));
      run($sformatf("table row %0d", r), TBL[r].uw,
          mk_insn(TBL[r].q, TBL[r].sz, TBL[r].op),
          TBL[r].uw ? ~TBL[r].q : TBL[r].q, TBL[r].sz,
          TBL[r].uw ? ~TBL[r].op : TBL[r].op, s, TBL[r].bad,
          TBL[r].bad ? 128'd0 : ref_perm(TBL[r].q, TBL[r].sz, TBL[r].op, s));
    end

    // Sweep R2 R3 R4 R5 R6 R7 in field mode and R8 in word mode
    for (int op = 0; op < 4; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int q = 0; q < 2; q++) begin
          logic [127:0] s;
          logic bad;
          s = {$urandom, $urandom, $urandom, $urandom};
          bad = ref_bad(2'(sz), 2'(op));
          run($sformatf("field op=%0d size=%0d q=%0d", op, sz, q), 1'b0, 32'h0,
              1'(q), 2'(sz), 2'(op), s, bad,
              bad ? 128'd0 : ref_perm(1'(q), 2'(sz), 2'(op), s));
          if (op != 3 || sz == 1) begin
            s = {$urandom, $urandom, $urandom, $urandom};
            run($sformatf("R8 word op=%0d size=%0d q=%0d", op, sz, q), 1'b1,
                mk_insn(1'(q), 2'(sz), 2'(op)), ~1'(q), ~2'(sz), ~2'(op), s, bad,
                bad ? 128'd0 : ref_perm(1'(q), 2'(sz), 2'(op), s));
          end
        end

    // R8: unrecognised words
    run("R8 zero word", 1'b1, 32'h0, 1'b1, 2'd0, 2'd0, '1, 1'b1, 128'd0);
    run("R8 bitrev size 00", 1'b1, mk_insn(1'b1, 2'd0, 2'd3) & ~32'h00C0_0000,
        1'b1, 2'd0, 2'd3, '1, 1'b1, 128'd0);

    // R6: upper half of source all ones, narrow form
    run("R6 upper ignored", 1'b0, 32'h0, 1'b0, 2'd0, 2'd1,
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0011_2233_4455_6677}, 1'b0,
        {64'd0, 64'h3322_1100_7766_5544});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule